// File: doc/BRIEF.md
# Banked RAM and ROM Overlay Mapper

This block sits between a 16-bit processor address bus and a physical memory system made of a base 64 KB RAM, up to eight further 64 KB expansion banks, and two ROM regions. A write to the shared control port whose top two data bits are both set loads a six-bit mapping register. That register holds an expansion bank number and one of eight fixed arrangements. Each arrangement assigns a 3-bit page to each of the four 16 KB windows of the processor address space. Pages 0 to 3 always lie in the base 64 KB. Pages 4 to 7 lie in the selected expansion bank.

On top of the RAM mapping, the lowest window (0000-3FFF) and the highest window (C000-FFFF) can each be overlaid by ROM for reads only, under two enable inputs. Writes to those windows always reach the RAM underneath. The mapper drives a 20-bit physical RAM address and mutually exclusive ROM and RAM chip selects. A separate video fetch path is passed straight to the base 64 KB, whatever the register holds. Choosing which ROM bank answers is left to other logic.

Top module: `bank_overlay_mapper`

## Requirements
- R1: When `io_wr` is high at a rising clock edge and `io_data[7:6]` equals 2'b11, the register loads `io_data[5:3]` as the expansion bank and `io_data[2:0]` as the arrangement. The new mapping is visible on the outputs from that edge onward.
- R2: An `io_wr` whose `io_data[7:6]` is not 2'b11, or any data presented while `io_wr` is low, leaves the register and therefore the mapping unchanged.
- R3: Reset (`rst_n` low, asynchronous) clears the register to zero. The mapping is then a plain 64 KB space: `ram_addr` = {4'b0, `cpu_addr`}.
- R4: Arrangements 0, 1, 2 and 3 give pages (window 0..3) of 0,1,2,3 / 0,1,2,7 / 4,5,6,7 / 0,3,2,7.
- R5: Arrangements 4, 5, 6 and 7 give pages 0,P,2,3, where P is 4, 5, 6 or 7 in that order.
- R6: `ram_addr` = {block[3:0], page[1:0], `cpu_addr[13:0]`}. The block is 0 for pages 0-3 and bank+1 for pages 4-7.
- R7: A read (`mem_rd` high, `mem_wr` low) with `cpu_addr[15:14]`=0 and `lo_rom_en` high asserts `rom_cs` and not `ram_cs`.
- R8: A read with `cpu_addr[15:14]`=3 and `hi_rom_en` high asserts `rom_cs` and not `ram_cs`. Windows 1 and 2 never select ROM.
- R9: A write (`mem_wr` high) always asserts `ram_cs` and never `rom_cs`, regardless of the ROM enables.
- R10: `rom_cs` and `ram_cs` are never high together, and both are low when neither `mem_rd` nor `mem_wr` is high.
- R11: `vid_ram_addr` = {4'b0, `vid_addr`} at all times, unaffected by the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_wr | input | 1 | Decoded write strobe of the shared control port |
| io_data | input | 8 | Control port write data |
| cpu_addr | input | 16 | Processor address |
| mem_rd | input | 1 | Memory read strobe |
| mem_wr | input | 1 | Memory write strobe |
| lo_rom_en | input | 1 | Enables the ROM overlay on window 0 reads |
| hi_rom_en | input | 1 | Enables the ROM overlay on window 3 reads |
| vid_addr | input | 16 | Video fetch address |
| ram_addr | output | 20 | Physical RAM address |
| ram_cs | output | 1 | RAM chip select |
| rom_cs | output | 1 | ROM chip select |
| vid_ram_addr | output | 20 | Physical video fetch address in the base 64 KB |

## Verification
The only register is the mapping register. A control port write therefore changes the mapping one clock edge later, while the address translation and the chip selects follow `cpu_addr`, the strobes and the enables within the same cycle. The bench drives the port write on one falling edge and removes it on the next. In between, one rising edge has loaded the register. It applies the access only after that edge and samples the outputs a few nanoseconds later, still inside the low clock phase. One directed check samples just before the loading edge to confirm that the old mapping still holds there.

// File: rtl/bank_map_pkg.sv
package bank_map_pkg;
    localparam int BANK_W = 3;   // expansion bank number width
    localparam int ARR_W  = 3;   // arrangement number width
    localparam int CPU_AW = 16;  // processor address width
    localparam int WIN_W  = 2;   // window selector width

    typedef struct packed {
        logic [BANK_W-1:0] bank;
        logic [ARR_W-1:0]  arr;
    } map_reg_t;
endpackage

// File: rtl/map_reg_ctl.sv
module map_reg_ctl
    import bank_map_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       io_wr,
    input  logic [7:0] io_data,
    output map_reg_t   map_q
);
    localparam int FIELD_W = BANK_W + ARR_W;

    typedef struct packed {
        map_reg_t map;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (io_wr && io_data[7:6] == 2'b11) begin
            st_d.map = map_reg_t'(io_data[FIELD_W-1:0]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign map_q = st_q.map;
endmodule

// File: rtl/map_page_xlate.sv
module map_page_xlate
    import bank_map_pkg::*;
#(
    parameter int BLOCK_W = BANK_W + 1,
    parameter int PHYS_W  = BLOCK_W + CPU_AW
)(
    input  map_reg_t          map_q,
    input  logic [CPU_AW-1:0] addr,
    output logic [PHYS_W-1:0] phys
);
    localparam int OFS_W = CPU_AW - WIN_W;

    logic [WIN_W-1:0]   win;
    logic [WIN_W:0]     page;
    logic [BLOCK_W-1:0] block;

    assign win = addr[CPU_AW-1:OFS_W];

    always_comb begin
        page = {1'b0, win};
        case (map_q.arr)
            3'd0: page = {1'b0, win};
            3'd1: page = (win == 2'd3) ? 3'd7 : {1'b0, win};
            3'd2: page = {1'b1, win};
            3'd3: begin
                if (win == 2'd1)      page = 3'd3;
                else if (win == 2'd3) page = 3'd7;
                else                  page = {1'b0, win};
            end
            default: page = (win == 2'd1) ? {1'b1, map_q.arr[1:0]} : {1'b0, win};
        endcase
    end

    always_comb begin
        if (page[WIN_W]) block = BLOCK_W'(map_q.bank) + BLOCK_W'(1);
        else             block = '0;
    end

    assign phys = {block, page[WIN_W-1:0], addr[OFS_W-1:0]};
endmodule

// File: rtl/map_chip_sel.sv
module map_chip_sel
    import bank_map_pkg::*;
(
    input  logic [WIN_W-1:0] win,
    input  logic             mem_rd,
    input  logic             mem_wr,
    input  logic             lo_rom_en,
    input  logic             hi_rom_en,
    output logic             rom_cs,
    output logic             ram_cs
);
    localparam logic [WIN_W-1:0] TOP_WIN = {WIN_W{1'b1}};

    logic is_rd;
    logic overlay;

    assign is_rd   = mem_rd && !mem_wr;
    assign overlay = (win == '0 && lo_rom_en) || (win == TOP_WIN && hi_rom_en);
    assign rom_cs  = is_rd && overlay;
    assign ram_cs  = mem_wr || (is_rd && !overlay);
endmodule

// File: rtl/bank_overlay_mapper.sv
module bank_overlay_mapper
    import bank_map_pkg::*;
#(
    parameter int BLOCK_W = BANK_W + 1,
    parameter int PHYS_W  = BLOCK_W + CPU_AW
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              io_wr,
    input  logic [7:0]        io_data,
    input  logic [CPU_AW-1:0] cpu_addr,
    input  logic              mem_rd,
    input  logic              mem_wr,
    input  logic              lo_rom_en,
    input  logic              hi_rom_en,
    input  logic [CPU_AW-1:0] vid_addr,
    output logic [PHYS_W-1:0] ram_addr,
    output logic              ram_cs,
    output logic              rom_cs,
    output logic [PHYS_W-1:0] vid_ram_addr
);
    map_reg_t cfg_q;

    map_reg_ctl u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .io_wr   (io_wr),
        .io_data (io_data),
        .map_q   (cfg_q)
    );

    map_page_xlate #(.BLOCK_W(BLOCK_W), .PHYS_W(PHYS_W)) u_xlate (
        .map_q (cfg_q),
        .addr  (cpu_addr),
        .phys  (ram_addr)
    );

    map_chip_sel u_sel (
        .win       (cpu_addr[CPU_AW-1:CPU_AW-WIN_W]),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr),
        .lo_rom_en (lo_rom_en),
        .hi_rom_en (hi_rom_en),
        .rom_cs    (rom_cs),
        .ram_cs    (ram_cs)
    );

    // Video fetches bypass the banking register entirely (R11).
    assign vid_ram_addr = {{BLOCK_W{1'b0}}, vid_addr};
endmodule

// File: rtl/bank_overlay_mapper_chk.sv
module bank_overlay_mapper_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        io_wr,
    input logic [7:0]  io_data,
    input logic [15:0] cpu_addr,
    input logic        mem_rd,
    input logic        mem_wr,
    input logic        lo_rom_en,
    input logic        hi_rom_en,
    input logic [19:0] ram_addr,
    input logic        ram_cs,
    input logic        rom_cs,
    input logic [5:0]  cfg_q
);
    assert_cs_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(rom_cs && ram_cs));

    assert_cs_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_rd && !mem_wr) |-> (!rom_cs && !ram_cs));

    assert_write_ram_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> (ram_cs && !rom_cs));

    assert_lo_overlay_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && !mem_wr && lo_rom_en && cpu_addr[15:14] == 2'd0) |-> rom_cs);

    assert_hi_overlay_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && !mem_wr && hi_rom_en && cpu_addr[15:14] == 2'd3) |-> rom_cs);

    assert_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_data[7:6] == 2'b11) |=> (cfg_q == $past(io_data[5:0])));

    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(io_wr && io_data[7:6] == 2'b11) |=> $stable(cfg_q));

    assert_base_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q[2:0] == 3'd0) |-> (ram_addr[19:16] == 4'd0));
endmodule

bind bank_overlay_mapper bank_overlay_mapper_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .io_wr     (io_wr),
    .io_data   (io_data),
    .cpu_addr  (cpu_addr),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .lo_rom_en (lo_rom_en),
    .hi_rom_en (hi_rom_en),
    .ram_addr  (ram_addr),
    .ram_cs    (ram_cs),
    .rom_cs    (rom_cs),
    .cfg_q     (cfg_q)
);

// File: tb/bank_overlay_mapper_test.sv
module bank_overlay_mapper_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        io_wr = 1'b0;
    logic [7:0]  io_data = '0;
    logic [15:0] cpu_addr = '0;
    logic        mem_rd = 1'b0;
    logic        mem_wr = 1'b0;
    logic        lo_rom_en = 1'b0;
    logic        hi_rom_en = 1'b0;
    logic [15:0] vid_addr = '0;
    logic [19:0] ram_addr;
    logic        ram_cs;
    logic        rom_cs;
    logic [19:0] vid_ram_addr;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    bank_overlay_mapper uut (
        .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_data(io_data),
        .cpu_addr(cpu_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .lo_rom_en(lo_rom_en), .hi_rom_en(hi_rom_en), .vid_addr(vid_addr),
        .ram_addr(ram_addr), .ram_cs(ram_cs), .rom_cs(rom_cs),
        .vid_ram_addr(vid_ram_addr)
    );

    // {ctl byte, addr, rd, wr, lo_en, hi_en, expected phys, exp rom_cs, exp ram_cs}
    localparam int NV = 18;
    localparam logic [49:0] VEC [NV] = '{
        {8'hC0, 16'h8123, 4'b1000, 20'h08123, 2'b01},  // R4 arr0
        {8'hC1, 16'hC010, 4'b1000, 20'h1C010, 2'b01},  // R4 arr1 page7
        {8'hC2, 16'h0005, 4'b1000, 20'h10005, 2'b01},  // R4 arr2 page4
        {8'hC2, 16'h4ABC, 4'b0100, 20'h14ABC, 2'b01},  // R4 arr2 page5 write
        {8'hD3, 16'h4001, 4'b1000, 20'h0C001, 2'b01},  // R4 arr3 page3
        {8'hD3, 16'hFFFF, 4'b1000, 20'h3FFFF, 2'b01},  // R6 bank2 page7
        {8'hEC, 16'h7FFF, 4'b1000, 20'h63FFF, 2'b01},  // R5 arr4 bank5
        {8'hFF, 16'h5555, 4'b0100, 20'h8D555, 2'b01},  // R6 bank7 -> block8
        {8'hFF, 16'hC100, 4'b1000, 20'h0C100, 2'b01},  // R5 arr7 window3 base
        {8'hCD, 16'h4000, 4'b1000, 20'h24000, 2'b01},  // R5 arr5 bank1
        {8'hC6, 16'h6000, 4'b1000, 20'h1A000, 2'b01},  // R5 arr6 bank0
        {8'hC0, 16'h0100, 4'b1010, 20'h00100, 2'b10},  // R7 low ROM read
        {8'hC0, 16'h0100, 4'b0110, 20'h00100, 2'b01},  // R9 low ROM write
        {8'hC2, 16'hC000, 4'b1001, 20'h1C000, 2'b10},  // R8 high ROM read
        {8'hC2, 16'hC000, 4'b0101, 20'h1C000, 2'b01},  // R9 high ROM write
        {8'hC2, 16'h2000, 4'b1001, 20'h12000, 2'b01},  // R8 high enable, low window
        {8'hC0, 16'h8000, 4'b1011, 20'h08000, 2'b01},  // R8 middle window never ROM
        {8'hC0, 16'h1234, 4'b0010, 20'h01234, 2'b00}   // R10 no strobe
    };

    function automatic string vreq(int i);
        case (i)
            0, 1, 2, 3, 4: return "R4";
            5, 7:          return "R6";
            6, 8, 9, 10:   return "R5";
            11:            return "R7";
            12, 14:        return "R9";
            13, 15, 16:    return "R8";
            default:       return "R10";
        endcase
    endfunction

    task automatic chk20(string req, logic [19:0] act, logic [19:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic chk_cs(string req, logic r, logic m, logic er, logic em);
        n_chk++;
        if ({r, m} !== {er, em}) begin
            n_bad++;
            $display("FAIL %s: rom_cs/ram_cs got %b%b expected %b%b", req, r, m, er, em);
        end
    endtask

    task automatic port_write(logic [7:0] d);
        @(negedge clk);
        io_wr = 1'b1; io_data = d;
        @(negedge clk);
        io_wr = 1'b0; io_data = 8'h00;
    endtask

    task automatic access(logic [15:0] a, logic rd, logic wr, logic lo, logic hi);
        cpu_addr = a; mem_rd = rd; mem_wr = wr; lo_rom_en = lo; hi_rom_en = hi;
        #2;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R3: reset state gives the plain 64 KB map
        access(16'hC123, 1'b1, 1'b0, 1'b0, 1'b0);
        chk20("R3", ram_addr, 20'h0C123);
        rst_n = 1'b1;
        @(negedge clk);
        access(16'h4567, 1'b1, 1'b0, 1'b0, 1'b0);
        chk20("R3", ram_addr, 20'h04567);

        for (int i = 0; i < NV; i++) begin
            port_write(VEC[i][49:42]);
            access(VEC[i][41:26], VEC[i][25], VEC[i][24], VEC[i][23], VEC[i][22]);
            chk20(vreq(i), ram_addr, VEC[i][21:2]);
            chk_cs(vreq(i), rom_cs, ram_cs, VEC[i][1], VEC[i][0]);
        end

        // R1: new value not visible before the loading edge, visible after
        port_write(8'hC0);
        @(negedge clk);
        io_wr = 1'b1; io_data = 8'hC2;
        access(16'h0000, 1'b1, 1'b0, 1'b0, 1'b0);
        chk20("R1", ram_addr, 20'h00000);
        @(negedge clk);
        io_wr = 1'b0; io_data = 8'h00;
        #2;
        chk20("R1", ram_addr, 20'h10000);

        // R2: wrong function codes and idle data leave the map alone
        port_write(8'h82);
        port_write(8'h47);
        port_write(8'h3F);
        @(negedge clk);
        io_data = 8'hD5;
        @(negedge clk);
        io_data = 8'h00;
        access(16'h0000, 1'b1, 1'b0, 1'b0, 1'b0);
        chk20("R2", ram_addr, 20'h10000);

        // R11: video path ignores the register (currently arrangement 2)
        vid_addr = 16'hBEEF;
        #2;
        chk20("R11", vid_ram_addr, 20'h0BEEF);
        port_write(8'hFF);
        vid_addr = 16'h4321;
        #2;
        chk20("R11", vid_ram_addr, 20'h04321);

        // R3: reset in mid-run clears the register again
        @(negedge clk);
        rst_n = 1'b0;
        access(16'h5000, 1'b1, 1'b0, 1'b0, 1'b0);
        chk20("R3", ram_addr, 20'h05000);
        @(negedge clk);
        rst_n = 1'b1;
        access(16'h0000, 1'b0, 1'b0, 1'b0, 1'b0);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_chk++;
                n_bad++;
                $display("FAIL watchdog: run did not complete, expected completion");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule